// File: doc/BRIEF.md
# Serial Management Slave for a 10/100 Ethernet PHY

This block is the station-management end of an Ethernet PHY. A management station sends serial frames on a shared bidirectional data line, MDIO, which is timed by a management clock, MDC. The block oversamples both lines with the PHY's own clock. It finds the start of each frame and checks the opcode and the 5-bit PHY address. It then serves a read or a write on a 32-entry space of 16-bit registers. Read data goes back through a tri-state output pair (`mdio_o` and `mdio_oe`), which the pad logic merges with the pulled-up line.

The register space has the usual special bit kinds:
- self-clearing command bits (soft reset, restart negotiation);
- latching-high event bits and a latching-low link bit;
- a clear-on-read event bit;
- an override enable that makes two capability bits writable. One of these capability bits lets frames come without a preamble.

Event inputs are single-cycle pulses or levels from the rest of the PHY. The control register is presented on `ctrl_o` for the datapath.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is, MSB first: at least 32 ones of preamble, start bits 0 then 1, a 2-bit opcode (10 = read, 01 = write), a 5-bit PHY address, a 5-bit register address, two turnaround bits and 16 data bits. MDIO is sampled on each rising MDC edge.
- R2: A start that follows fewer than 32 consecutive ones is ignored, unless the preamble-suppression bit (register 1 bit 6) is set. While that bit is set, a frame may begin with no preamble.
- R3: On a matching read, the slave leaves MDIO undriven in turnaround bit 1 and drives 0 in turnaround bit 2. It then drives data bits 15 down to 0, each updated after a rising MDC edge, and releases the line in the bit period after data bit 0.
- R4: A frame with a different PHY address, or with opcode 00 or 11, changes no register and never drives MDIO.
- R5: Register 0 has read/write bits at 14 (loopback), 13 (speed, default 1), 12 (negotiation enable, default 1), 11 (power down) and 8 (duplex). Bit 10 (isolate) defaults to 1 exactly when the address strapped at reset is 00000, and to 0 otherwise. Bits 7:0 read 0. `ctrl_o` shows the register 0 value.
- R6: Writing 1 to register 0 bit 15 returns every register to its default and the frame logic to idle; bit 15 then reads 0. Writing 1 to bit 9 gives a one-cycle pulse on `ctrl_o[9]`, and the bit reads 0.
- R7: Register 1 bits 14:12 and bit 0 always read 1. Bit 11 (default 1) and bit 6 (default 0) take written values only while register 16 bit 15 is 1; otherwise writes to register 1 are ignored.
- R8: Register 1 bit 1 (jabber) and bit 4 (remote fault) latch high on their event pulses and stay set until register 1 is read. The read returns 1 and clears them. Bit 5 follows the `an_done` level.
- R9: Register 1 bit 2 (link) latches low when `link_up` falls and stays 0 until register 1 is read. The read reloads it with the current `link_up`. It is 0 after reset.
- R10: Register 18 bit 15 latches the remote-jabber pulse and clears when register 18 is read; the other bits of register 18 read 0.
- R11: Register 2 reads 16'h0015. Register 3 reads {6'h3D, model 6'd4, revision 4'd1}. Registers that are not implemented read 0.
- R12: Register 16 bit 15 is the read/write override enable (default 0). Bits 10:6 read the strapped PHY address, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PHY clock that oversamples MDC and MDIO |
| rst_n | input | 1 | Asynchronous active-low reset; captures `phy_addr` |
| phy_addr | input | 5 | Strapped PHY address |
| mdc | input | 1 | Management clock from the station |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | Value driven onto MDIO while enabled |
| mdio_oe | output | 1 | MDIO output enable |
| link_up | input | 1 | Current link level |
| an_done | input | 1 | Negotiation-complete level |
| ev_jabber | input | 1 | Jabber event pulse |
| ev_rfault | input | 1 | Remote-fault event pulse |
| ev_rjab | input | 1 | Remote-jabber event pulse |
| ctrl_o | output | 16 | Current register 0 contents |

## Verification
Frame acceptance is probed at the preamble boundary: 31 ones must be ignored and 32 accepted. A frame with no preamble is sent both with and without the suppression bit set. An off-by-one counter would accept the short frame or reject the minimal one.

Turnaround and release are sampled bit by bit. A slave that drives early would collide with the station in turnaround bit 1, and one that releases late would block the next frame.

The latch bits are read twice after a single event. A design that cleared on every cycle, or never cleared, shows the wrong value on one of the two reads. Writes to register 1 are tried with and without the override, and mismatched or illegal frames are sent to confirm that nothing is written and the line is never driven.

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
  parameter int          PRE_LEN    = 32,
  parameter int          RST_CYCLES = 8,
  parameter logic [15:0] ID_HI      = 16'h0015,
  parameter logic [5:0]  OUI_LO     = 6'h3D,
  parameter logic [5:0]  MODEL      = 6'd4,
  parameter logic [3:0]  REV        = 4'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  phy_addr,
  input  logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        link_up,
  input  logic        an_done,
  input  logic        ev_jabber,
  input  logic        ev_rfault,
  input  logic        ev_rjab,
  output logic [15:0] ctrl_o
);
  localparam int CW = $clog2(PRE_LEN + 1);
  localparam int RW = $clog2(RST_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ST, S_HDR, S_TA, S_DATA} st_t;

  logic [2:0]    mdc_s;
  logic [1:0]    mdio_s;
  st_t           st;
  logic [CW-1:0] pre_cnt;
  logic [3:0]    cnt;
  logic [10:0]   hdr;
  logic [15:0]   sh;
  logic          is_rd, is_wr;
  logic [4:0]    ra;
  logic [4:0]    addr_q;
  logic [RW-1:0] srst_cnt;

  logic loopb, speed, anen, pdown, isol, anrst, dplx;
  logic ovr, cap11, cap6;
  logic l_jab, l_rf, l_lnk, l_rj;

  wire rise   = mdc_s[1] & ~mdc_s[2];
  wire bit_in = mdio_s[1];
  wire init   = srst_cnt != '0;

  wire [11:0] hdr_n  = {hdr, bit_in};
  wire        hdr_ok = hdr_n[9:5] == addr_q;
  wire        hdr_rd = hdr_ok && hdr_n[11:10] == 2'b10;
  wire        hdr_wr = hdr_ok && hdr_n[11:10] == 2'b01;

  wire        rd_fire = rise && st == S_HDR && cnt == 4'd11 && hdr_rd;
  wire        wr_fire = rise && st == S_DATA && cnt == 4'd15 && is_wr;
  wire [15:0] wd      = {sh[14:0], bit_in};
  wire        clr1    = rd_fire && hdr_n[4:0] == 5'd1;
  wire        clr18   = rd_fire && hdr_n[4:0] == 5'd18;

  wire [15:0] r0  = {init, loopb, speed, anen, pdown, isol, anrst, dplx, 8'h00};
  wire [15:0] r1  = {1'b0, 3'b111, cap11, 4'b0000, cap6, an_done, l_rf, 1'b0, l_lnk, l_jab, 1'b1};
  wire [15:0] r3  = {OUI_LO, MODEL, REV};
  wire [15:0] r16 = {ovr, 4'b0000, addr_q, 6'b000000};
  wire [15:0] r18 = {l_rj, 15'b0};

  logic [15:0] rd_mux;
  always_comb begin
    case (hdr_n[4:0])
      5'd0:    rd_mux = r0;
      5'd1:    rd_mux = r1;
      5'd2:    rd_mux = ID_HI;
      5'd3:    rd_mux = r3;
      5'd16:   rd_mux = r16;
      5'd18:   rd_mux = r18;
      default: rd_mux = 16'h0000;
    endcase
  end

  assign ctrl_o = r0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_s  <= 3'b000;
      mdio_s <= 2'b11;
    end else begin
      mdc_s  <= {mdc_s[1:0], mdc};
      mdio_s <= {mdio_s[0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pre_cnt <= '0;
      cnt     <= '0;
      hdr     <= '0;
      sh      <= '0;
      is_rd   <= 1'b0;
      is_wr   <= 1'b0;
      ra      <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (init) begin
      st      <= S_IDLE;
      pre_cnt <= '0;
      mdio_oe <= 1'b0;
      is_rd   <= 1'b0;
      is_wr   <= 1'b0;
    end else if (rise) begin
      case (st)
        S_IDLE: begin
          if (bit_in) begin
            if (pre_cnt != CW'(PRE_LEN)) pre_cnt <= pre_cnt + 1'b1;
          end else begin
            if (pre_cnt == CW'(PRE_LEN) || cap6) st <= S_ST;
            pre_cnt <= '0;
          end
        end
        S_ST: begin
          cnt <= '0;
          st  <= bit_in ? S_HDR : S_IDLE;
        end
        S_HDR: begin
          hdr <= hdr_n[10:0];
          cnt <= cnt + 1'b1;
          if (cnt == 4'd11) begin
            st    <= S_TA;
            cnt   <= '0;
            is_rd <= hdr_rd;
            is_wr <= hdr_wr;
            ra    <= hdr_n[4:0];
            if (hdr_rd) sh <= rd_mux;
          end
        end
        S_TA: begin
          if (cnt == 4'd0) begin
            cnt <= 4'd1;
            if (is_rd) begin
              mdio_oe <= 1'b1;
              mdio_o  <= 1'b0;
            end
          end else begin
            st     <= S_DATA;
            cnt    <= '0;
            mdio_o <= sh[15];
            sh     <= {sh[14:0], bit_in};
          end
        end
        S_DATA: begin
          mdio_o <= sh[15];
          sh     <= {sh[14:0], bit_in};
          cnt    <= cnt + 1'b1;
          if (cnt == 4'd15) begin
            mdio_oe <= 1'b0;
            st      <= S_IDLE;
            pre_cnt <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_cnt <= '0;
      addr_q   <= phy_addr;
      loopb <= 1'b0; speed <= 1'b1; anen <= 1'b1; pdown <= 1'b0;
      isol  <= phy_addr == 5'd0; anrst <= 1'b0; dplx <= 1'b0;
      ovr   <= 1'b0; cap11 <= 1'b1; cap6 <= 1'b0;
      l_jab <= 1'b0; l_rf <= 1'b0; l_lnk <= 1'b0; l_rj <= 1'b0;
    end else if (init) begin
      srst_cnt <= srst_cnt - 1'b1;
      addr_q   <= phy_addr;
      loopb <= 1'b0; speed <= 1'b1; anen <= 1'b1; pdown <= 1'b0;
      isol  <= phy_addr == 5'd0; anrst <= 1'b0; dplx <= 1'b0;
      ovr   <= 1'b0; cap11 <= 1'b1; cap6 <= 1'b0;
      l_jab <= 1'b0; l_rf <= 1'b0; l_lnk <= 1'b0; l_rj <= 1'b0;
    end else begin
      anrst <= 1'b0;
      l_jab <= ev_jabber | (l_jab & ~clr1);
      l_rf  <= ev_rfault | (l_rf & ~clr1);
      l_lnk <= clr1 ? link_up : (l_lnk & link_up);
      l_rj  <= ev_rjab | (l_rj & ~clr18);
      if (wr_fire) begin
        case (ra)
          5'd0: begin
            if (wd[15]) srst_cnt <= RW'(RST_CYCLES);
            else begin
              loopb <= wd[14]; speed <= wd[13]; anen  <= wd[12];
              pdown <= wd[11]; isol  <= wd[10]; anrst <= wd[9];
              dplx  <= wd[8];
            end
          end
          5'd1: if (ovr) begin
            cap11 <= wd[11];
            cap6  <= wd[6];
          end
          5'd16: ovr <= wd[15];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdio_oe,
  input logic        mdio_o,
  input logic        rise,
  input logic [15:0] ctrl,
  input logic        link_up,
  input logic        ev_jabber,
  input logic        ev_rjab,
  input logic        l_jab,
  input logic        l_lnk,
  input logic        l_rj
);
  p_ta_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);
  p_oe_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_oe) |-> $past(rise));
  p_restart_sc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[9] |=> !ctrl[9]);
  p_reset_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[15] |-> !mdio_oe);
  p_jab_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_jabber && !ctrl[15]) |=> l_jab);
  p_link_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> !l_lnk);
  p_rjab_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rjab && !ctrl[15]) |=> l_rj);
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdio_oe(mdio_oe), .mdio_o(mdio_o), .rise(rise),
  .ctrl(ctrl_o), .link_up(link_up), .ev_jabber(ev_jabber), .ev_rjab(ev_rjab),
  .l_jab(l_jab), .l_lnk(l_lnk), .l_rj(l_rj)
);

// File: tb/tb_mdio_mgmt_slave.sv
module tb_mdio_mgmt_slave;
  localparam logic [15:0] ID_HI = 16'h0015;
  localparam logic [15:0] ID_LO = {6'h3D, 6'd4, 4'd1};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [4:0] strap = 5'd3;
  logic mdc = 1'b0, tb_drv = 1'b0, tb_val = 1'b1;
  logic link_up = 1'b1, an_done = 1'b0;
  logic ev_jabber = 1'b0, ev_rfault = 1'b0, ev_rjab = 1'b0;
  logic mdio_o, mdio_oe;
  logic [15:0] ctrl_o;
  wire mdio_line = mdio_oe ? mdio_o : (tb_drv ? tb_val : 1'b1);

  mdio_mgmt_slave dut (
    .clk(clk), .rst_n(rst_n), .phy_addr(strap), .mdc(mdc), .mdio_i(mdio_line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .link_up(link_up), .an_done(an_done),
    .ev_jabber(ev_jabber), .ev_rfault(ev_rfault), .ev_rjab(ev_rjab), .ctrl_o(ctrl_o)
  );

  int nchk = 0, nerr = 0, pulses = 0;
  always @(negedge clk) if (ctrl_o[9]) pulses++;

  logic e_loopb, e_speed, e_anen, e_pdown, e_isol, e_dplx, e_ovr, e_cap11, e_cap6;
  logic e_ljab, e_lrf, e_llnk, e_lrj;

  task automatic m_defaults();
    e_loopb = 0; e_speed = 1; e_anen = 1; e_pdown = 0; e_isol = (strap == 5'd0);
    e_dplx = 0; e_ovr = 0; e_cap11 = 1; e_cap6 = 0;
    e_ljab = 0; e_lrf = 0; e_llnk = 0; e_lrj = 0;
  endtask

  function automatic logic [15:0] exp_reg(input logic [4:0] a);
    case (a)
      5'd0:  return {1'b0, e_loopb, e_speed, e_anen, e_pdown, e_isol, 1'b0, e_dplx, 8'h00};
      5'd1:  return {1'b0, 3'b111, e_cap11, 4'b0, e_cap6, an_done, e_lrf, 1'b0, e_llnk, e_ljab, 1'b1};
      5'd2:  return ID_HI;
      5'd3:  return ID_LO;
      5'd16: return {e_ovr, 4'b0, strap, 6'b0};
      5'd18: return {e_lrj, 15'b0};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic m_write(input logic [4:0] a, input logic [15:0] d);
    case (a)
      5'd0: if (d[15]) m_defaults();
            else begin
              e_loopb = d[14]; e_speed = d[13]; e_anen = d[12];
              e_pdown = d[11]; e_isol = d[10]; e_dplx = d[8];
            end
      5'd1: if (e_ovr) begin e_cap11 = d[11]; e_cap6 = d[6]; end
      5'd16: e_ovr = d[15];
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bitx(input logic drv, input logic val, output logic oe_s, output logic v_s);
    @(negedge clk);
    mdc = 1'b0; tb_drv = drv; tb_val = val;
    repeat (4) @(negedge clk);
    oe_s = mdio_oe; v_s = mdio_line;
    mdc = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Every frame ends with one released idle bit (a 1), counted in the next preamble.
  task automatic frame(input int npre, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] ra, input logic [15:0] wd,
                       output logic [15:0] rd, output logic ta_ok,
                       output logic rel_ok, output logic any_oe);
    logic o, v, o1, v1, o2, v2, rdm;
    logic [13:0] hd;
    hd = {2'b01, op, phy, ra};
    rdm = (op == 2'b10);
    any_oe = 0; rd = '0;
    for (int i = 0; i < npre; i++) begin bitx(1'b1, 1'b1, o, v); any_oe |= o; end
    for (int i = 13; i >= 0; i--) begin bitx(1'b1, hd[i], o, v); any_oe |= o; end
    bitx(!rdm, 1'b1, o1, v1);
    bitx(!rdm, 1'b0, o2, v2);
    any_oe |= o1 | o2;
    ta_ok = !o1 && o2 && !v2;
    for (int i = 15; i >= 0; i--) begin bitx(!rdm, wd[i], o, v); any_oe |= o; rd[i] = v; end
    bitx(1'b0, 1'b1, o, v);
    rel_ok = !o;
    any_oe |= o;
  endtask

  task automatic do_read(input logic [4:0] a, input string tag, input int npre = 32);
    logic [15:0] rd; logic ta, rel, ao;
    frame(npre, 2'b10, strap, a, 16'h0, rd, ta, rel, ao);
    chk(tag, rd, exp_reg(a));
    chk("R3 turnaround", {15'b0, ta}, 16'h1);
    chk("R3 release", {15'b0, rel}, 16'h1);
    if (a == 5'd1) begin e_ljab = 0; e_lrf = 0; e_llnk = link_up; end
    if (a == 5'd18) e_lrj = 0;
  endtask

  task automatic do_write(input logic [4:0] a, input logic [15:0] d, input int npre = 32);
    logic [15:0] rd; logic ta, rel, ao;
    frame(npre, 2'b01, strap, a, d, rd, ta, rel, ao);
    chk("R4 write leaves line undriven", {15'b0, ao}, 16'h0);
    m_write(a, d);
    if (a == 5'd0 && d[15]) for (int i = 0; i < 4; i++) bitx(1'b0, 1'b1, ta, rel);
  endtask

  task automatic idle1();
    logic o, v;
    bitx(1'b0, 1'b1, o, v);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_jabber = 1;
      1: ev_rfault = 1;
      default: ev_rjab = 1;
    endcase
    @(negedge clk);
    ev_jabber = 0; ev_rfault = 0; ev_rjab = 0;
    case (which)
      0: e_ljab = 1;
      1: e_lrf = 1;
      default: e_lrj = 1;
    endcase
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog R1: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [15:0] rd; logic ta, rel, ao;
    int p0;
    logic [4:0] alist [7];
    alist = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd16, 5'd18, 5'd9};
    void'($urandom(32'd20240607));
    m_defaults();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 ctrl_o reset value", ctrl_o, 16'h3000);
    idle1();

    do_read(5'd0, "R5 reg0 default");
    do_read(5'd2, "R11 id high");
    do_read(5'd3, "R11 id low");
    do_read(5'd9, "R11 unmapped reads zero");
    do_read(5'd16, "R12 reg16 default");
    do_read(5'd1, "R9 link latch zero after reset");
    do_read(5'd1, "R9 link reloaded by read");

    do_write(5'd0, 16'h4900);
    do_read(5'd0, "R5 reg0 write readback");
    chk("R5 ctrl_o mirrors", ctrl_o, exp_reg(5'd0));
    p0 = pulses;
    do_write(5'd0, 16'h4300);
    chk("R6 restart pulse one cycle", 16'(pulses - p0), 16'd1);
    do_read(5'd0, "R6 restart bit reads zero");

    do_write(5'd1, 16'h0040);
    do_read(5'd1, "R7 capability write ignored without override");
    do_write(5'd16, 16'hFFFF);
    do_read(5'd16, "R12 override set, address field");
    do_write(5'd1, 16'h0040);
    do_read(5'd1, "R7 capability bits written with override");

    do_read(5'd0, "R2 no preamble with suppression", 0);
    do_write(5'd1, 16'h0800);
    do_read(5'd1, "R7 suppression cleared");

    // 30 + trailing idle = 31 ones: must be rejected
    frame(30, 2'b01, strap, 5'd0, 16'h0100, rd, ta, rel, ao);
    do_read(5'd0, "R2 31-one preamble ignored");
    // 31 + trailing idle = 32 ones: accepted
    do_write(5'd0, 16'h0100, 31);
    do_read(5'd0, "R1 32-one preamble accepted");

    frame(32, 2'b11, strap, 5'd0, 16'h4000, rd, ta, rel, ao);
    chk("R4 opcode 11 no drive", {15'b0, ao}, 16'h0);
    frame(32, 2'b00, strap, 5'd0, 16'h4000, rd, ta, rel, ao);
    chk("R4 opcode 00 no drive", {15'b0, ao}, 16'h0);
    frame(32, 2'b10, strap ^ 5'd1, 5'd0, 16'h0, rd, ta, rel, ao);
    chk("R4 foreign read no drive", {15'b0, ao}, 16'h0);
    frame(32, 2'b01, strap ^ 5'd4, 5'd0, 16'h4000, rd, ta, rel, ao);
    do_read(5'd0, "R4 registers unchanged");

    pulse(0);
    an_done = 1;
    do_read(5'd1, "R8 jabber latched, negotiation level");
    do_read(5'd1, "R8 jabber cleared by read");
    pulse(1);
    do_read(5'd1, "R8 remote fault latched");
    do_read(5'd1, "R8 remote fault cleared");

    @(negedge clk); link_up = 0;
    repeat (3) @(negedge clk); link_up = 1; e_llnk = 0;
    do_read(5'd1, "R9 link drop held");
    do_read(5'd1, "R9 link restored after read");

    pulse(2);
    do_read(5'd18, "R10 remote jabber latched");
    do_read(5'd18, "R10 remote jabber cleared on read");

    do_write(5'd16, 16'h8000);
    do_write(5'd0, 16'h8000);
    chk("R6 ctrl_o after soft reset", ctrl_o, 16'h3000);
    do_read(5'd0, "R6 soft reset defaults, bit 15 clear");
    do_read(5'd16, "R6 override cleared by soft reset");

    for (int n = 0; n < 100; n++) begin
      logic [31:0] r;
      logic [4:0] a;
      logic [15:0] d;
      r = $urandom;
      a = alist[r[4:2] % 7];
      d = 16'($urandom);
      if (r[11:8] != 4'd0) d[15] = (a == 5'd16) ? d[15] : 1'b0;
      if (r[14:12] == 3'd0) pulse(int'(r[16:15] % 3));
      an_done = r[17];
      if (r[0]) do_write(a, d);
      else do_read(a, "R1 random read");
    end

    rst_n = 0; strap = 5'd0;
    repeat (3) @(negedge clk);
    m_defaults();
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R5 isolate default at address zero", ctrl_o, 16'h3400);
    idle1();
    do_read(5'd0, "R5 reg0 at address zero");
    do_read(5'd16, "R12 strapped address zero");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule